// File: doc/BRIEF.md
# Half-Precision Scaled Rounder

This block takes one 16-bit half-precision operand and rounds it to a chosen binary granularity. A 4-bit scale field M in an 8-bit control byte sets how many fraction bits survive. The result is the operand rounded to the nearest multiple of 2^-M under the selected rounding direction, and it is returned as a half-precision value. The rounding direction comes from the low two bits of the control byte or from a 2-bit mode held in an external control register, chosen per operation. A further control bit masks the inexact report.

The unit has one register stage. The result, an inexact flag and an invalid flag appear one clock after the operand and control are presented. Subnormal operands are handled in the datapath. There is no handshake: every clock starts a new operation.

Top module: `fp16_scale_round`

## Requirements
- R1: The result equals RoundToInt(x·2^M)·2^-M, with M = ctrlIn[7:4]. Mode code 00 rounds to nearest with ties to even.
- R2: ctrlIn[2] = 0 takes the rounding mode from ctrlIn[1:0]. ctrlIn[2] = 1 takes it from extMode[1:0].
- R3: Mode code 01 rounds toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R4: peFlag is 1 exactly when a finite operand's result differs from the operand and ctrlIn[3] = 0. With ctrlIn[3] = 1, peFlag stays 0.
- R5: A signaling NaN (exponent 11111, fraction bit 9 = 0, nonzero fraction) is returned with fraction bit 9 set and ieFlag = 1. A quiet NaN is returned unchanged with ieFlag = 0.
- R6: Infinities and zeros of either sign are returned unchanged with both flags 0.
- R7: The result keeps the operand's sign bit, including a negative zero when a negative value rounds to zero.
- R8: An operand whose unbiased exponent is at least 10−M is returned bit-exact with no flag. No finite operand ever yields an infinity.
- R9: A round-up that carries out of the significand moves the result to the next binade.
- R10: A magnitude below 2^-M becomes ±2^-M when it rounds away from zero and a signed zero otherwise.
- R11: Subnormal operands use exponent −14 with no hidden bit, and a result below the normal range is encoded as a subnormal.
- R12: The outputs are registered with one cycle of latency, and an active-low reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opIn | input | 16 | Half-precision operand |
| ctrlIn | input | 8 | Control byte: [7:4] scale, [3] inexact mask, [2] mode source, [1:0] mode |
| extMode | input | 2 | Rounding mode from the external control register |
| resOut | output | 16 | Rounded half-precision result |
| peFlag | output | 1 | Inexact flag |
| ieFlag | output | 1 | Invalid flag, raised for a signaling NaN operand |

## Verification
The block holds no state beyond its output register, so any internal fault shows on the very next cycle after the operand that exposes it. A wrong drop count or a wrong mode decode gives a result off by one unit of 2^-M. A bad normaliser moves the exponent field, or turns a tiny result into a normal instead of a subnormal. A bad class decode shows as a NaN or infinity that comes back altered or flagged. The vectors are chosen so that each of these paths gives its own distinct wrong value.

// File: rtl/fp16rs_pkg.sv
package fp16rs_pkg;
  localparam int EXP_W  = 5;
  localparam int MAN_W  = 10;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int SCL_W  = 4;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN   = 1 - BIAS;
  localparam int MAXDROP = SIG_W + 1;
  localparam int WIDE_W = SIG_W + MAXDROP + 1;
  localparam int QR_W   = SIG_W + 1;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic               bypass;
    logic               isNan;
    logic               raiseInv;
    logic               keepPe;
    rmode_e             mode;
    logic [SCL_W-1:0]   scale;
  } rsStrobes_t;
endpackage

// File: rtl/fp16rs_ctrl.sv
module fp16rs_ctrl
  import fp16rs_pkg::*;
(
  input  logic [WORD_W-2:0] magIn,
  input  logic [7:0]        ctrlIn,
  input  logic [1:0]        extMode,
  output rsStrobes_t        strobes
);
  logic [EXP_W-1:0] expF;
  logic [MAN_W-1:0] fracF;
  logic expMax;
  logic expZero;

  always_comb begin
    expF    = magIn[WORD_W-2:MAN_W];
    fracF   = magIn[MAN_W-1:0];
    expMax  = &expF;
    expZero = ~|expF;

    strobes.isNan    = expMax && (fracF != '0);
    strobes.raiseInv = strobes.isNan && !fracF[MAN_W-1];
    strobes.bypass   = expMax || (expZero && (fracF == '0));
    strobes.keepPe   = !ctrlIn[3];
    strobes.scale    = ctrlIn[7:4];
    strobes.mode     = ctrlIn[2] ? rmode_e'(extMode) : rmode_e'(ctrlIn[1:0]);
  end
endmodule

// File: rtl/fp16rs_datapath.sv
module fp16rs_datapath
  import fp16rs_pkg::*;
(
  input  logic [WORD_W-1:0] opIn,
  input  rsStrobes_t        strobes,
  output logic [WORD_W-1:0] resNext,
  output logic              peNext,
  output logic              ieNext
);
  logic                   sgn;
  logic [EXP_W-1:0]       expF;
  logic [MAN_W-1:0]       fracF;
  logic [SIG_W-1:0]       sig;
  logic signed [6:0]      unbE;
  logic signed [7:0]      dropCnt;
  logic                   alreadyExact;
  logic [3:0]             dSh;
  logic [WIDE_W-1:0]      wide;
  logic [SIG_W-1:0]       qInt;
  logic                   rBit;
  logic                   sBit;
  logic                   inexact;
  logic                   incr;
  logic [QR_W-1:0]        qr;
  logic [3:0]             lead;
  logic signed [6:0]      resE;
  logic [EXP_W-1:0]       resExpF;
  logic [MAN_W-1:0]       resFrac;
  logic [4:0]             subSh;
  logic [WORD_W-1:0]      rounded;

  // Drop count and right shift that splits kept bits, round bit and sticky.
  always_comb begin
    sgn   = opIn[WORD_W-1];
    expF  = opIn[WORD_W-2:MAN_W];
    fracF = opIn[MAN_W-1:0];
    sig   = {(expF != '0), fracF};
    unbE  = (expF == '0) ? 7'(EMIN) : ($signed({2'b00, expF}) - 7'(BIAS));
    dropCnt = 8'(MAN_W) - $signed({unbE[6], unbE}) - $signed({4'b0000, strobes.scale});
    alreadyExact = (dropCnt <= 8'sd0);
    if (alreadyExact)                 dSh = 4'd0;
    else if (dropCnt > 8'(MAXDROP))   dSh = 4'(MAXDROP);
    else                              dSh = dropCnt[3:0];
    wide    = {sig, {(MAXDROP+1){1'b0}}} >> dSh;
    qInt    = wide[WIDE_W-1:MAXDROP+1];
    rBit    = wide[MAXDROP];
    sBit    = |wide[MAXDROP-1:0];
    inexact = rBit || sBit;
  end

  // Direction decision.
  always_comb begin
    case (strobes.mode)
      RM_NEAREST: incr = rBit && (sBit || qInt[0]);
      RM_DOWN:    incr = inexact && sgn;
      RM_UP:      incr = inexact && !sgn;
      default:    incr = 1'b0;
    endcase
    qr = {1'b0, qInt} + QR_W'(incr);
  end

  // Renormalise qr * 2^-M into half precision.
  always_comb begin
    lead = 4'd0;
    for (int i = 0; i < QR_W; i++) begin
      if (qr[i]) lead = 4'(i);
    end
    resE    = $signed({3'b000, lead}) - $signed({3'b000, strobes.scale});
    subSh   = 5'(MAN_W - EMIN) - {1'b0, strobes.scale};
    resExpF = '0;
    resFrac = '0;
    if (qr == '0) begin
      resExpF = '0;
      resFrac = '0;
    end else if (resE >= 7'(EMIN)) begin
      resExpF = EXP_W'(resE + 7'(BIAS));
      resFrac = (lead > 4'(MAN_W)) ? '0 : MAN_W'(qr << (4'(MAN_W) - lead));
    end else begin
      resExpF = '0;
      resFrac = MAN_W'(qr << subSh);
    end
    rounded = {sgn, resExpF, resFrac};
  end

  // Result selection.
  always_comb begin
    ieNext = 1'b0;
    peNext = 1'b0;
    if (strobes.isNan) begin
      resNext = {sgn, expF, 1'b1, fracF[MAN_W-2:0]};
      ieNext  = strobes.raiseInv;
    end else if (strobes.bypass || alreadyExact) begin
      resNext = opIn;
    end else begin
      resNext = rounded;
      peNext  = inexact && strobes.keepPe;
    end
  end
endmodule

// File: rtl/fp16_scale_round.sv
module fp16_scale_round
  import fp16rs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] opIn,
  input  logic [7:0]  ctrlIn,
  input  logic [1:0]  extMode,
  output logic [15:0] resOut,
  output logic        peFlag,
  output logic        ieFlag
);
  rsStrobes_t        strobes;
  logic [WORD_W-1:0] resNext;
  logic              peNext;
  logic              ieNext;

  fp16rs_ctrl u_ctrl (
    .magIn   (opIn[WORD_W-2:0]),
    .ctrlIn  (ctrlIn),
    .extMode (extMode),
    .strobes (strobes)
  );

  fp16rs_datapath u_dp (
    .opIn    (opIn),
    .strobes (strobes),
    .resNext (resNext),
    .peNext  (peNext),
    .ieNext  (ieNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resOut <= '0;
      peFlag <= 1'b0;
      ieFlag <= 1'b0;
    end else begin
      resOut <= resNext;
      peFlag <= peNext;
      ieFlag <= ieNext;
    end
  end
endmodule

// File: rtl/fp16rs_chk.sv
module fp16rs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] opIn,
  input logic [7:0]  ctrlIn,
  input logic [15:0] resOut,
  input logic        peFlag,
  input logic        ieFlag
);
  logic pastValid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  // R5: an invalid report always carries a quiet NaN.
  a_r5_inv_quiet_nan: assert property (@(posedge clk) disable iff (!rst_n)
    ieFlag |-> ((&resOut[14:10]) && resOut[9]));

  // R4: NaN handling never reports inexact alongside invalid.
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ieFlag && peFlag));

  // R4: a masked operation never reports inexact.
  a_r4_masked_pe: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(ctrlIn[3])) |-> !peFlag);

  // R7: sign bit follows the operand.
  a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> (resOut[15] == $past(opIn[15])));

  // R8: a finite operand never yields an all-ones exponent.
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && !(&$past(opIn[14:10]))) |-> !(&resOut[14:10]));

  // R6: infinity operand comes back unchanged.
  a_r6_inf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && ($past(opIn[14:0]) == 15'h7C00)) |-> (resOut == $past(opIn) && !peFlag && !ieFlag));
endmodule

bind fp16_scale_round fp16rs_chk u_chk (.*);

// File: tb/fp16_scale_round_tb.sv
module fp16_scale_round_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opIn = '0;
  logic [7:0]  ctrlIn = '0;
  logic [1:0]  extMode = '0;
  logic [15:0] resOut;
  logic        peFlag;
  logic        ieFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fp16_scale_round u_dut (.*);

  // {operand, control, ext mode, expected result, pe, ie, requirement}
  localparam int NV = 35;
  localparam logic [63:0] VEC [NV] = '{
    {16'h4100, 8'h00, 8'h0, 16'h4000, 4'h1, 4'h0, 8'd1},   // R1 2.5 -> 2
    {16'h3D00, 8'h10, 8'h0, 16'h3C00, 4'h1, 4'h0, 8'd1},   // R1 tie to even at M=1
    {16'h3D00, 8'h20, 8'h0, 16'h3D00, 4'h0, 4'h0, 8'd1},   // R1 exact at M=2
    {16'h4300, 8'h00, 8'h0, 16'h4400, 4'h1, 4'h0, 8'd9},   // R9 3.5 -> 4
    {16'h3F00, 8'h10, 8'h0, 16'h4000, 4'h1, 4'h0, 8'd9},   // R9 1.75 -> 2
    {16'hBF00, 8'h11, 8'h0, 16'hC000, 4'h1, 4'h0, 8'd9},   // R9 negative carry
    {16'hC100, 8'h01, 8'h0, 16'hC200, 4'h1, 4'h0, 8'd3},   // R3 down
    {16'hC100, 8'h02, 8'h0, 16'hC000, 4'h1, 4'h0, 8'd3},   // R3 up
    {16'hC100, 8'h03, 8'h0, 16'hC000, 4'h1, 4'h0, 8'd3},   // R3 zero
    {16'h4100, 8'h02, 8'h0, 16'h4200, 4'h1, 4'h0, 8'd3},   // R3 up positive
    {16'h4100, 8'h04, 8'h2, 16'h4200, 4'h1, 4'h0, 8'd2},   // R2 external up
    {16'h4100, 8'h06, 8'h1, 16'h4000, 4'h1, 4'h0, 8'd2},   // R2 external overrides
    {16'h4100, 8'h02, 8'h1, 16'h4200, 4'h1, 4'h0, 8'd2},   // R2 external ignored
    {16'h4100, 8'h08, 8'h0, 16'h4000, 4'h0, 4'h0, 8'd4},   // R4 masked
    {16'h4100, 8'h0A, 8'h0, 16'h4200, 4'h0, 4'h0, 8'd4},   // R4 masked up
    {16'h3C00, 8'h00, 8'h0, 16'h3C00, 4'h0, 4'h0, 8'd4},   // R4 exact no flag
    {16'h7D00, 8'h00, 8'h0, 16'h7F00, 4'h0, 4'h1, 8'd5},   // R5 sNaN
    {16'hFC01, 8'h00, 8'h0, 16'hFE01, 4'h0, 4'h1, 8'd5},   // R5 negative sNaN
    {16'h7E01, 8'h00, 8'h0, 16'h7E01, 4'h0, 4'h0, 8'd5},   // R5 qNaN
    {16'h7C00, 8'h03, 8'h0, 16'h7C00, 4'h0, 4'h0, 8'd6},   // R6 +inf
    {16'hFC00, 8'h02, 8'h0, 16'hFC00, 4'h0, 4'h0, 8'd6},   // R6 -inf
    {16'h0000, 8'h02, 8'h0, 16'h0000, 4'h0, 4'h0, 8'd6},   // R6 +0
    {16'h8000, 8'h01, 8'h0, 16'h8000, 4'h0, 4'h0, 8'd6},   // R6 -0
    {16'hB400, 8'h00, 8'h0, 16'h8000, 4'h1, 4'h0, 8'd7},   // R7 -0.25 nearest
    {16'hB400, 8'h03, 8'h0, 16'h8000, 4'h1, 4'h0, 8'd7},   // R7 -0.25 zero
    {16'hB400, 8'h01, 8'h0, 16'hBC00, 4'h1, 4'h0, 8'd7},   // R7 -0.25 down
    {16'h3400, 8'h02, 8'h0, 16'h3C00, 4'h1, 4'h0, 8'd10},  // R10 0.25 up
    {16'h1400, 8'h32, 8'h0, 16'h3000, 4'h1, 4'h0, 8'd10},  // R10 tiny up M=3
    {16'h1400, 8'h31, 8'h0, 16'h0000, 4'h1, 4'h0, 8'd10},  // R10 tiny down
    {16'h7BFF, 8'hF0, 8'h0, 16'h7BFF, 4'h0, 4'h0, 8'd8},   // R8 max finite M=15
    {16'h7BFF, 8'h02, 8'h0, 16'h7BFF, 4'h0, 4'h0, 8'd8},   // R8 max finite up
    {16'h0001, 8'hF2, 8'h0, 16'h0200, 4'h1, 4'h0, 8'd11},  // R11 subnormal up
    {16'h0300, 8'hF0, 8'h0, 16'h0400, 4'h1, 4'h0, 8'd11},  // R11 to min normal
    {16'h0200, 8'hF0, 8'h0, 16'h0200, 4'h0, 4'h0, 8'd11},  // R11 exact subnormal
    {16'h0001, 8'h00, 8'h0, 16'h0000, 4'h1, 4'h0, 8'd11}   // R11 subnormal to zero
  };

  task automatic checkOut(input int req, input logic [15:0] expRes,
                          input logic expPe, input logic expIe);
    checks++;
    if (resOut !== expRes || peFlag !== expPe || ieFlag !== expIe) begin
      errors++;
      $display("FAIL R%0d: got res=%h pe=%b ie=%b, expected res=%h pe=%b ie=%b",
               req, resOut, peFlag, ieFlag, expRes, expPe, expIe);
    end
  endtask

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk);
    opIn = 16'h4100;
    @(negedge clk);
    checkOut(12, 16'h0000, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      opIn    = VEC[v][63:48];
      ctrlIn  = VEC[v][47:40];
      extMode = VEC[v][33:32];
      @(negedge clk);
      checkOut(int'(VEC[v][7:0]), VEC[v][31:16], VEC[v][12], VEC[v][8]);
    end

    // R12: one cycle latency, output holds the previous operand's result
    opIn = 16'hC100; ctrlIn = 8'h01;
    @(negedge clk);
    opIn = 16'h7D00; ctrlIn = 8'h00;
    @(posedge clk);
    #1;
    checkOut(12, 16'h7F00, 1'b0, 1'b1);
    @(negedge clk);
    // R12: asynchronous reset clears outputs mid-run
    rst_n = 1'b0;
    #1;
    checkOut(12, 16'h0000, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    opIn = 16'h3F00; ctrlIn = 8'h18;  // R4 masked and R9 carry
    @(negedge clk);
    checkOut(4, 16'h4000, 1'b0, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R12: watchdog expired, got no finish, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule